// File: doc/BRIEF.md
# I2C SCL Timing Generator with High-Speed Switch

This block turns a fast source clock into the serial-clock waveform of an I2C master, together with single-cycle strobes that tell the byte sequencer when to drive a new data bit and when to capture the incoming one. Three counters set the time base: a pre-divider, a step counter and a sample counter. Each half of the serial-clock period lasts (pre-divider × sample count × step count) source cycles, so a full bit lasts twice that.

Two sets of timing fields are presented in 16-bit register form. The normal set covers standard and fast operation, and also the master-code byte that opens a high-speed transfer. The high-speed set is armed by a mode code in its low bits. It takes over at the first bit boundary after the sequencer reports that the master code has been sent. All fields are captured when a transaction starts, so software writes made during a transfer do not disturb it.

Top module: `i2c_scl_timing_gen`

## Requirements
- R1: While `run` is low (and after reset) `scl` is high and `launch_tick`, `sample_tick` and `bit_tick` are all low.
- R2: Let S = `norm_timing[10:8]`+1, T = `norm_timing[5:0]`+1 and P = `prediv_m1`+1. In the normal phase the low half and the high half of `scl` each last S·T·P cycles.
- R3: `launch_tick` pulses exactly once per low half. The pulse comes floor(S/2)·T·P cycles after the first low cycle.
- R4: `sample_tick` pulses exactly once per high half. The pulse comes floor(S/2)·T·P cycles after the first high cycle.
- R5: `bit_tick` pulses on the last cycle of every high half, and nowhere else.
- R6: `scl` goes low in the cycle after the first clock edge that samples `run` high. That cycle is the first cycle of bit 0.
- R7: All timing inputs are captured at the start of a transaction. Later changes to `norm_timing`, `hs_timing` or `prediv_m1` have no effect until the next start.
- R8: High-speed mode is armed only when `hs_timing[1:0]` equals 3. The high-speed sample count is `hs_timing[14:12]`+1 and the high-speed step count is `hs_timing[10:8]`+1.
- R9: When `mcode_done` pulses while high-speed mode is armed, the current bit still uses the normal fields. From the next bit onward the high-speed fields are used, and `hs_active` is high from the first cycle of that next bit.
- R10: When high-speed mode is not armed, `mcode_done` is ignored: `hs_active` stays low and the timing stays normal.
- R11: Dropping `run` clears `hs_active`, so the next transaction starts with the normal fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Transaction active; a rising level starts one |
| norm_timing | input | 16 | Normal fields: sample−1 in [10:8], step−1 in [5:0] |
| hs_timing | input | 16 | High-speed fields: sample−1 in [14:12], step−1 in [10:8], mode code in [1:0] |
| prediv_m1 | input | 8 | Pre-divider minus one |
| mcode_done | input | 1 | One-cycle pulse from the sequencer once the master code is sent |
| scl | output | 1 | Serial clock level |
| launch_tick | output | 1 | Drive-data strobe, in the middle of the low half |
| sample_tick | output | 1 | Capture-data strobe, in the middle of the high half |
| bit_tick | output | 1 | Last cycle of each bit |
| hs_active | output | 1 | High-speed fields in use |

## Verification
The assertions assume that `run` holds steady for whole bits and that `mcode_done` is a one-cycle pulse given while a transaction is running. The bench raises and drops `run` only on cycle boundaries it has counted out, and it pulses `mcode_done` only at the first cycle of a bit. It sweeps every sample count with several step counts and pre-divider values. It also covers the armed and unarmed high-speed cases, a late master-code report, and field changes made in the middle of a transfer.

// File: rtl/i2c_tg_pkg.sv
// Shared field layout and decode helpers for the SCL timing generator.
// Assumes 16-bit timing registers whose field positions are fixed by the sequencer.
package i2c_tg_pkg;
    parameter int REG_W     = 16;
    parameter int SAMP_W    = 3;
    parameter int STEP_W    = 6;
    parameter int HS_STEP_W = 3;

    localparam int NORM_SAMP_LSB = 8;
    localparam int NORM_STEP_LSB = 0;
    localparam int HS_SAMP_LSB   = 12;
    localparam int HS_STEP_LSB   = 8;
    localparam logic [1:0] HS_ARM_CODE = 2'b11;

    typedef struct packed {
        logic [SAMP_W-1:0] samp_m1;
        logic [STEP_W-1:0] step_m1;
    } tg_fields_t;

    // Pull the normal-phase counts out of the normal register image
    function automatic tg_fields_t decode_norm(input logic [REG_W-1:0] r);
        tg_fields_t f;
        f.samp_m1 = r[NORM_SAMP_LSB +: SAMP_W];
        f.step_m1 = r[NORM_STEP_LSB +: STEP_W];
        return f;
    endfunction

    // Pull the high-speed counts out of the high-speed register image
    function automatic tg_fields_t decode_hs(input logic [REG_W-1:0] r);
        tg_fields_t f;
        f.samp_m1 = r[HS_SAMP_LSB +: SAMP_W];
        f.step_m1 = {{(STEP_W-HS_STEP_W){1'b0}}, r[HS_STEP_LSB +: HS_STEP_W]};
        return f;
    endfunction

    // High-speed mode is armed only by the exact mode code
    function automatic logic hs_armed(input logic [REG_W-1:0] r);
        return r[1:0] == HS_ARM_CODE;
    endfunction
endpackage

// File: rtl/tg_field_latch.sv
// Captures the timing fields at transaction start and selects the active set.
// Assumes mcode_done is a single-cycle pulse and bit_end marks a bit's last cycle.
module tg_field_latch
    import i2c_tg_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [REG_W-1:0] norm_reg,
    input  logic [REG_W-1:0] hs_reg,
    input  logic [PRE_W-1:0] prediv_in,
    input  logic             mcode_done,
    input  logic             bit_end,
    output tg_fields_t       act_fields,
    output logic [PRE_W-1:0] prediv_q,
    output logic             hs_act
);
    tg_fields_t norm_q, hs_q;
    logic       armed_q, pend_q;
    logic       req_now;
    logic       unused_bits;

    assign unused_bits = ^{norm_reg[REG_W-1:11], norm_reg[7:6], hs_reg[REG_W-1], hs_reg[11], hs_reg[7:2]};
    assign req_now     = mcode_done && armed_q;

    // Capture fields at start; track the master-code switch up to a bit boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            norm_q   <= '0;
            hs_q     <= '0;
            armed_q  <= 1'b0;
            prediv_q <= '0;
            pend_q   <= 1'b0;
            hs_act   <= 1'b0;
        end else if (start) begin
            norm_q   <= decode_norm(norm_reg);
            hs_q     <= decode_hs(hs_reg);
            armed_q  <= hs_armed(hs_reg);
            prediv_q <= prediv_in;
            pend_q   <= 1'b0;
            hs_act   <= 1'b0;
        end else if (!run) begin
            pend_q   <= 1'b0;
            hs_act   <= 1'b0;
        end else if (bit_end && (pend_q || req_now)) begin
            hs_act   <= 1'b1;
            pend_q   <= 1'b0;
        end else if (req_now && !hs_act) begin
            pend_q   <= 1'b1;
        end
    end

    // Active field set follows the phase flag
    always_comb act_fields = hs_act ? hs_q : norm_q;
endmodule

// File: rtl/tg_prescale.sv
// Fixed-ratio pre-divider: emits one tick every (div_m1+1) cycles while enabled.
// Assumes div_m1 is held stable while enabled.
module tg_prescale #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PRE_W-1:0] div_m1,
    output logic             tick,
    output logic             at_zero
);
    logic [PRE_W-1:0] cnt;

    assign tick    = en && (cnt == div_m1);
    assign at_zero = (cnt == '0);

    // Count source cycles, wrapping on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tg_phase_counter.sv
// Nested step/sample counters; toggles the SCL phase after each full half.
// Assumes the field inputs change only at a bit boundary.
module tg_phase_counter
    import i2c_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  tg_fields_t        fields,
    output logic              phase,
    output logic [STEP_W-1:0] step_cnt,
    output logic [SAMP_W-1:0] samp_cnt,
    output logic              half_end
);
    logic step_wrap;

    assign step_wrap = tick && (step_cnt == fields.step_m1);
    assign half_end  = step_wrap && (samp_cnt == fields.samp_m1);

    // Advance step on each pre-divided tick, sample on each step wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            step_cnt <= '0;
            samp_cnt <= '0;
            phase    <= 1'b0;
        end else if (tick) begin
            if (step_wrap) begin
                step_cnt <= '0;
                if (half_end) begin
                    samp_cnt <= '0;
                    phase    <= ~phase;
                end else begin
                    samp_cnt <= samp_cnt + 1'b1;
                end
            end else begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_scl_timing_gen.sv
// SCL timing generator: pre-divider plus sample/step counters, with a
// mid-transaction switch to high-speed fields after the master code.
// Assumes run is held for whole bits and mcode_done is a one-cycle pulse.
module i2c_scl_timing_gen
    import i2c_tg_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [REG_W-1:0] norm_timing,
    input  logic [REG_W-1:0] hs_timing,
    input  logic [PRE_W-1:0] prediv_m1,
    input  logic             mcode_done,
    output logic             scl,
    output logic             launch_tick,
    output logic             sample_tick,
    output logic             bit_tick,
    output logic             hs_active
);
    logic              running, start;
    tg_fields_t        fields;
    logic [PRE_W-1:0]  pre_q;
    logic              pre_tick, pre_zero;
    logic              phase, half_end;
    logic [STEP_W-1:0] step_cnt;
    logic [SAMP_W-1:0] samp_cnt;
    logic [SAMP_W:0]   samp_n;
    logic [SAMP_W-1:0] mid_idx;
    logic              unit_start;

    assign start = run && !running;

    // Transaction active flag, one cycle behind run
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= run;
    end

    tg_field_latch #(.PRE_W(PRE_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .run        (run),
        .norm_reg   (norm_timing),
        .hs_reg     (hs_timing),
        .prediv_in  (prediv_m1),
        .mcode_done (mcode_done),
        .bit_end    (bit_tick),
        .act_fields (fields),
        .prediv_q   (pre_q),
        .hs_act     (hs_active)
    );

    tg_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (running),
        .div_m1  (pre_q),
        .tick    (pre_tick),
        .at_zero (pre_zero)
    );

    tg_phase_counter u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (running),
        .tick     (pre_tick),
        .fields   (fields),
        .phase    (phase),
        .step_cnt (step_cnt),
        .samp_cnt (samp_cnt),
        .half_end (half_end)
    );

    // Midpoint unit index: floor of sample count over two
    always_comb begin
        samp_n  = {1'b0, fields.samp_m1} + 1'b1;
        mid_idx = samp_n[SAMP_W:1];
    end

    // Strobes and the serial clock level
    always_comb begin
        unit_start  = running && pre_zero && (step_cnt == '0);
        launch_tick = unit_start && !phase && (samp_cnt == mid_idx);
        sample_tick = unit_start &&  phase && (samp_cnt == mid_idx);
        bit_tick    = half_end && phase;
        scl         = !running || phase;
    end
endmodule

// File: rtl/i2c_scl_timing_gen_chk.sv
// Property checker for the SCL timing generator, bound to the top module.
// Assumes the bench holds run for whole bits.
module i2c_scl_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic scl,
    input logic launch_tick,
    input logic sample_tick,
    input logic bit_tick,
    input logic hs_active
);
    a_r1_idle_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> scl);
    a_r1_idle_no_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !(launch_tick || sample_tick || bit_tick));
    a_r3_launch_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        launch_tick |-> !scl);
    a_r4_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> scl);
    a_r5_bit_end_then_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && run) |=> !scl);
    a_r9_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_active) |-> $past(bit_tick));
    a_r11_drop_clears_hs: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !hs_active);
endmodule

bind i2c_scl_timing_gen i2c_scl_timing_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .scl         (scl),
    .launch_tick (launch_tick),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick),
    .hs_active   (hs_active)
);

// File: tb/sim_i2c_scl_timing_gen.sv
module sim_i2c_scl_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] norm_timing = '0;
    logic [15:0] hs_timing = '0;
    logic [7:0]  prediv_m1 = '0;
    logic        mcode_done = 1'b0;
    logic        scl, launch_tick, sample_tick, bit_tick, hs_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_scl_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .norm_timing(norm_timing),
        .hs_timing(hs_timing), .prediv_m1(prediv_m1), .mcode_done(mcode_done),
        .scl(scl), .launch_tick(launch_tick), .sample_tick(sample_tick),
        .bit_tick(bit_tick), .hs_active(hs_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Measure one bit from its first low cycle; ends at the next bit's first cycle.
    task automatic measure_bit(input bit pulse_mc, input bit chg_fields,
                               output int lo, output int hi, output int lof,
                               output int sof, output int bt, output int nl, output int ns);
        lo = 0; hi = 0; lof = -1; sof = -1; bt = -1; nl = 0; ns = 0;
        if (pulse_mc) mcode_done = 1'b1;
        while (scl == 1'b0) begin
            if (launch_tick) begin nl++; if (lof < 0) lof = lo; end
            if (sample_tick || bit_tick) ns = ns + 100;
            lo++;
            @(negedge clk);
            mcode_done = 1'b0;
            if (chg_fields) begin norm_timing = 16'h0000; prediv_m1 = 8'd0; hs_timing = 16'h0000; end
        end
        while (scl == 1'b1 && lo < 100000) begin
            if (sample_tick) begin ns++; if (sof < 0) sof = hi; end
            if (launch_tick) nl = nl + 100;
            if (bit_tick) bt = hi;
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic stop_run();
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Single-bit normal run with full timing checks (R2 to R6)
    task automatic sweep_one(input int pm1, input int s, input int t);
        int lo, hi, lof, sof, bt, nl, ns, h;
        prediv_m1   = 8'(pm1);
        norm_timing = 16'(((s - 1) << 8) | (t - 1));
        hs_timing   = 16'h0000;
        run = 1'b1;
        @(negedge clk);
        chk("R6 scl low after start", int'(scl), 0);
        measure_bit(1'b0, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        h = s * t * (pm1 + 1);
        chk("R2 low half", lo, h);
        chk("R2 high half", hi, h);
        chk("R3 launch offset", lof, (s / 2) * t * (pm1 + 1));
        chk("R3 launch count", nl, 1);
        chk("R4 sample offset", sof, (s / 2) * t * (pm1 + 1));
        chk("R4 sample count", ns, 1);
        chk("R5 bit_tick at last", bt, h - 1);
        stop_run();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lo, hi, lof, sof, bt, nl, ns;
        int steps[5] = '{1, 2, 3, 5, 64};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset / idle state
        chk("R1 idle scl", int'(scl), 1);
        chk("R1 idle ticks", int'(launch_tick | sample_tick | bit_tick | hs_active), 0);

        for (int p = 0; p < 3; p++)
            for (int s = 1; s <= 8; s++)
                for (int k = 0; k < 5; k++)
                    sweep_one(p, s, steps[k]);

        // R8/R9: armed high-speed, pulse in bit 0; norm S=4 T=3, hs S=3 T=2, P=2
        prediv_m1 = 8'd1; norm_timing = 16'h0302; hs_timing = 16'h2103;
        run = 1'b1; @(negedge clk);
        measure_bit(1'b1, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        chk("R9 master-code bit normal", lo + hi, 48);
        chk("R9 hs_active at next bit", int'(hs_active), 1);
        measure_bit(1'b0, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        chk("R8 hs low half", lo, 12);
        chk("R8 hs high half", hi, 12);
        chk("R8 hs launch offset", lof, 4);
        stop_run();
        chk("R11 hs cleared on drop", int'(hs_active), 0);

        // R11: new transaction after hs starts normal
        run = 1'b1; @(negedge clk);
        measure_bit(1'b0, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        chk("R11 restart normal", lo + hi, 48);
        chk("R11 hs_active low", int'(hs_active), 0);
        stop_run();

        // R9: late pulse in bit 1; bit 1 still normal, bit 2 high-speed
        run = 1'b1; @(negedge clk);
        measure_bit(1'b0, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        chk("R9 bit0 normal", lo + hi, 48);
        measure_bit(1'b1, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        chk("R9 pulse bit normal", lo + hi, 48);
        measure_bit(1'b0, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        chk("R9 after pulse hs", lo + hi, 24);
        stop_run();

        // R10: unarmed mode code 2 -> pulse ignored
        hs_timing = 16'h2102;
        run = 1'b1; @(negedge clk);
        measure_bit(1'b1, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        measure_bit(1'b0, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        chk("R10 stays normal", lo + hi, 48);
        chk("R10 hs_active low", int'(hs_active), 0);
        stop_run();

        // R7: fields changed mid-transfer have no effect
        hs_timing = 16'h2103; norm_timing = 16'h0302; prediv_m1 = 8'd1;
        run = 1'b1; @(negedge clk);
        measure_bit(1'b0, 1'b1, lo, hi, lof, sof, bt, nl, ns);
        chk("R7 bit0 unchanged", lo + hi, 48);
        measure_bit(1'b1, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        chk("R7 bit1 unchanged", lo + hi, 48);
        measure_bit(1'b0, 1'b0, lo, hi, lof, sof, bt, nl, ns);
        chk("R7 latched hs fields", lo + hi, 24);
        stop_run();
        chk("R1 idle after stop", int'(scl), 1);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule